// File: doc/BRIEF.md
# Nine-Bit Multidrop Address Filter

This block sits between a UART core and the rest of the receive and transmit logic and adds nine-bit multidrop addressing. Each character exchanged with the core is nine bits wide. When nine-bit mode is on, a set ninth bit marks the character as an address. On receive, an address character can be compared with a programmable local address. Data characters then pass only while the most recent address matched, so a node on a shared bus sees only the traffic that is meant for it. Every address character that is forwarded is marked with a status flag.

On transmit, software can request that a programmable destination address be sent with its ninth bit set. The address goes out ahead of any further data, and the request bit then clears itself. A transmit mode bit lets the host supply the ninth bit of each data character directly. Otherwise the ninth bit of data is forced low.

Software must not change the local address in the middle of a received frame. A write made while the receiver reports a frame in progress is therefore held until that frame ends.

Top module: `nba_addr_filter`

## Requirements
- R1: After reset, the control value reads 0, both address registers read 0, rx_out_valid and tx_out_valid are 0, and the match state is cleared.
- R2: When control bit 0 (nine-bit enable) is 0, every received character is forwarded with rx_out_data equal to its low 8 bits and rx_out_addr equal to 0. Every transmitted data character leaves with its ninth bit (bit 8) at 0.
- R3: When bit 0 is 1 and control bit 1 (match enable) is 0, every received character is forwarded, and rx_out_addr equals its bit 8.
- R4: When bits 0 and 1 are both 1, an address character (bit 8 set) whose low 8 bits equal the receive address is forwarded with rx_out_addr 1 and sets the match state. Any other address character is dropped and clears the match state.
- R5: In match mode, a data character (bit 8 clear) is forwarded only while the match state is set. Before the first matching address, data is dropped.
- R6: A forwarded received character appears on the rx outputs exactly one clock after it is presented, and rx_out_valid lasts one cycle.
- R7: A receive-address write made while rx_busy is 1 does not change the receive address. The last such write takes effect on the first clock on which rx_busy is 0. A write made while rx_busy is 0 takes effect on the next clock.
- R8: When bit 0 is 1 and control bit 3 (transmit mode) is 1, a transmitted data character keeps the ninth bit supplied by the host. Otherwise the ninth bit is 0.
- R9: Writing control bit 2 (send address) with bit 0 set queues the character {1, transmit address}. It is loaded ahead of any pending host data, bit 2 then reads 0, and host data is refused while it is pending. Writing bit 2 with bit 0 clear stores 0 and sends nothing.
- R10: While tx_out_valid is 1 and tx_out_ready is 0, tx_out_valid and tx_out_data stay unchanged.
- R11: Whenever bit 0 or bit 1 is 0, the match state is cleared. After match mode is turned off and on again, data is dropped until a matching address arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 4 | Control value: bit0 nine-bit enable, bit1 match enable, bit2 send address, bit3 transmit mode |
| rxa_we | input | 1 | Write strobe for the receive address |
| rxa_wdata | input | 8 | Receive address write value |
| txa_we | input | 1 | Write strobe for the transmit address |
| txa_wdata | input | 8 | Transmit address write value |
| ctl_q | output | 4 | Current control value |
| rx_addr_q | output | 8 | Receive address in use |
| tx_addr_q | output | 8 | Transmit address |
| rx_busy | input | 1 | Core reports a receive frame in progress |
| rx_in_valid | input | 1 | Received character strobe from the core |
| rx_in_data | input | 9 | Received character, bit 8 is the ninth bit |
| rx_out_valid | output | 1 | Forwarded character strobe |
| rx_out_data | output | 8 | Forwarded character |
| rx_out_addr | output | 1 | Status flag: forwarded character is an address |
| tx_in_valid | input | 1 | Host offers a transmit character |
| tx_in_data | input | 9 | Host character, bit 8 used only in transmit mode |
| tx_in_ready | output | 1 | Host character accepted on this clock |
| tx_out_valid | output | 1 | Character offered to the core |
| tx_out_data | output | 9 | Character to the core, bit 8 is the ninth bit |
| tx_out_ready | input | 1 | Core takes the offered character |

## Verification
In each of the four combinations of nine-bit enable and match enable, the receive side is given every 8-bit address value, each followed by a data character. This separates pass-all, flag-only and filtering behaviour, and it shows that exactly one address value matches. Further receive sequences send data before any address, write the address while a frame is in progress, and switch match mode off and back on. These show whether the match state and the deferred address write are handled correctly. On the transmit side, the same host character is sent in each mode to show where the ninth bit comes from. A send-address request raised while data is still outstanding shows the ordering and the self-clear.

// File: rtl/nba_pkg.sv
package nba_pkg;
  // Control register layout; bit 0 is the LSB (nine-bit enable).
  typedef struct packed {
    logic tx_mode;   // bit 3: host supplies ninth bit
    logic send_req;  // bit 2: send transmit address
    logic match_en;  // bit 1: receive address filtering
    logic nine_en;   // bit 0: nine-bit characters
  } ctl_t;
  localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/nba_ctl_regs.sv
module nba_ctl_regs
  import nba_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_we,
  input  ctl_t          ctl_wdata,
  input  logic          rxa_we,
  input  logic [AW-1:0] rxa_wdata,
  input  logic          txa_we,
  input  logic [AW-1:0] txa_wdata,
  input  logic          rx_busy,
  input  logic          send_done,
  output ctl_t          ctl,
  output logic [AW-1:0] rx_addr,
  output logic [AW-1:0] tx_addr
);
  logic          pend_v;
  logic [AW-1:0] pend_a;
  ctl_t          ctl_nxt;

  always_comb begin
    ctl_nxt = ctl;
    if (ctl_we) begin
      ctl_nxt = ctl_wdata;
      ctl_nxt.send_req = ctl_wdata.send_req & ctl_wdata.nine_en;
    end else if (send_done) begin
      ctl_nxt.send_req = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl     <= '0;
      rx_addr <= '0;
      tx_addr <= '0;
      pend_v  <= 1'b0;
      pend_a  <= '0;
    end else begin
      ctl <= ctl_nxt;
      if (txa_we) tx_addr <= txa_wdata;
      if (rxa_we && !rx_busy) begin
        rx_addr <= rxa_wdata;
        pend_v  <= 1'b0;
      end else if (rxa_we) begin
        pend_a <= rxa_wdata;
        pend_v <= 1'b1;
      end else if (pend_v && !rx_busy) begin
        rx_addr <= pend_a;
        pend_v  <= 1'b0;
      end
    end
  end

  // R7: the address in use never moves across a busy clock
  assert_rxaddr_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    rx_busy |=> $stable(rx_addr));

  // R9: a send request is never stored without nine-bit mode
  assert_send_needs_nine_R9: assert property (@(posedge clk) disable iff (rst)
    ctl.send_req |-> ctl.nine_en);
endmodule

// File: rtl/nba_rx_filter.sv
module nba_rx_filter #(
  parameter int AW = 8,
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          nine_en,
  input  logic          match_en,
  input  logic [AW-1:0] rx_addr,
  input  logic          in_valid,
  input  logic [CW-1:0] in_data,
  output logic          out_valid,
  output logic [AW-1:0] out_data,
  output logic          out_addr
);
  logic matched;
  logic filt_on;
  logic is_addr;
  logic hit;
  logic pass;

  always_comb begin
    filt_on = nine_en & match_en;
    is_addr = nine_en & in_data[AW];
    hit     = (in_data[AW-1:0] == rx_addr);
    if (!filt_on)     pass = 1'b1;
    else if (is_addr) pass = hit;
    else              pass = matched;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      matched   <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_addr  <= 1'b0;
    end else begin
      out_valid <= in_valid & pass;
      if (in_valid) begin
        out_data <= in_data[AW-1:0];
        out_addr <= is_addr;
      end
      if (!filt_on)                 matched <= 1'b0;
      else if (in_valid && is_addr) matched <= hit;
    end
  end

  // R6: output strobe only one cycle after an input strobe
  assert_out_follows_in_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  // R3: the address flag needs nine-bit mode at capture
  assert_flag_needs_nine_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_addr) |-> $past(nine_en));

  // R11: no match state outside match mode
  assert_match_cleared_R11: assert property (@(posedge clk) disable iff (rst)
    !(nine_en && match_en) |=> !matched);
endmodule

// File: rtl/nba_tx_mux.sv
module nba_tx_mux #(
  parameter int AW = 8,
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          nine_en,
  input  logic          tx_mode,
  input  logic          send_req,
  input  logic [AW-1:0] tx_addr,
  input  logic          in_valid,
  input  logic [CW-1:0] in_data,
  output logic          in_ready,
  output logic          send_done,
  output logic          out_valid,
  output logic [CW-1:0] out_data,
  input  logic          out_ready
);
  logic can_load;
  logic ninth;

  always_comb begin
    can_load  = !out_valid || out_ready;
    send_done = can_load & send_req;
    in_ready  = can_load & !send_req;
    ninth     = nine_en & tx_mode & in_data[AW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (can_load) begin
      if (send_req) begin
        out_valid <= 1'b1;
        out_data  <= {1'b1, tx_addr};
      end else if (in_valid) begin
        out_valid <= 1'b1;
        out_data  <= {ninth, in_data[AW-1:0]};
      end else begin
        out_valid <= 1'b0;
      end
    end
  end

  // R10: a stalled character holds
  assert_hold_stalled_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R9: a granted send request yields an address character
  assert_send_is_addr_R9: assert property (@(posedge clk) disable iff (rst)
    send_done |=> (out_valid && out_data[AW]));
endmodule

// File: rtl/nba_addr_filter.sv
module nba_addr_filter
  import nba_pkg::*;
#(
  parameter int AW = 8,
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             rxa_we,
  input  logic [AW-1:0]    rxa_wdata,
  input  logic             txa_we,
  input  logic [AW-1:0]    txa_wdata,
  output logic [CTL_W-1:0] ctl_q,
  output logic [AW-1:0]    rx_addr_q,
  output logic [AW-1:0]    tx_addr_q,
  input  logic             rx_busy,
  input  logic             rx_in_valid,
  input  logic [CW-1:0]    rx_in_data,
  output logic             rx_out_valid,
  output logic [AW-1:0]    rx_out_data,
  output logic             rx_out_addr,
  input  logic             tx_in_valid,
  input  logic [CW-1:0]    tx_in_data,
  output logic             tx_in_ready,
  output logic             tx_out_valid,
  output logic [CW-1:0]    tx_out_data,
  input  logic             tx_out_ready
);
  ctl_t          ctl;
  logic          send_done;
  logic [AW-1:0] rx_addr;
  logic [AW-1:0] tx_addr;

  nba_ctl_regs #(.AW(AW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_t'(ctl_wdata)),
    .rxa_we    (rxa_we),
    .rxa_wdata (rxa_wdata),
    .txa_we    (txa_we),
    .txa_wdata (txa_wdata),
    .rx_busy   (rx_busy),
    .send_done (send_done),
    .ctl       (ctl),
    .rx_addr   (rx_addr),
    .tx_addr   (tx_addr)
  );

  nba_rx_filter #(.AW(AW)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .nine_en   (ctl.nine_en),
    .match_en  (ctl.match_en),
    .rx_addr   (rx_addr),
    .in_valid  (rx_in_valid),
    .in_data   (rx_in_data),
    .out_valid (rx_out_valid),
    .out_data  (rx_out_data),
    .out_addr  (rx_out_addr)
  );

  nba_tx_mux #(.AW(AW)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .nine_en   (ctl.nine_en),
    .tx_mode   (ctl.tx_mode),
    .send_req  (ctl.send_req),
    .tx_addr   (tx_addr),
    .in_valid  (tx_in_valid),
    .in_data   (tx_in_data),
    .in_ready  (tx_in_ready),
    .send_done (send_done),
    .out_valid (tx_out_valid),
    .out_data  (tx_out_data),
    .out_ready (tx_out_ready)
  );

  assign ctl_q     = ctl;
  assign rx_addr_q = rx_addr;
  assign tx_addr_q = tx_addr;
endmodule

// File: tb/sim_nba_addr_filter.sv
module sim_nba_addr_filter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_we = 1'b0;
  logic [3:0] ctl_wdata = '0;
  logic       rxa_we = 1'b0;
  logic [7:0] rxa_wdata = '0;
  logic       txa_we = 1'b0;
  logic [7:0] txa_wdata = '0;
  logic [3:0] ctl_q;
  logic [7:0] rx_addr_q;
  logic [7:0] tx_addr_q;
  logic       rx_busy = 1'b0;
  logic       rx_in_valid = 1'b0;
  logic [8:0] rx_in_data = '0;
  logic       rx_out_valid;
  logic [7:0] rx_out_data;
  logic       rx_out_addr;
  logic       tx_in_valid = 1'b0;
  logic [8:0] tx_in_data = '0;
  logic       tx_in_ready;
  logic       tx_out_valid;
  logic [8:0] tx_out_data;
  logic       tx_out_ready = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model of the receive side
  bit       m_nine = 0, m_match = 0, m_hit = 0;
  bit [7:0] m_rxa = 0;

  always #10 clk = ~clk;

  nba_addr_filter u0 (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr_ctl(logic [3:0] v);
    ctl_we = 1'b1; ctl_wdata = v; tick(); ctl_we = 1'b0;
    m_nine = v[0]; m_match = v[1];
    if (!(v[0] && v[1])) m_hit = 0;
  endtask

  task automatic wr_rxa(logic [7:0] v);
    rxa_we = 1'b1; rxa_wdata = v; tick(); rxa_we = 1'b0;
  endtask

  task automatic wr_txa(logic [7:0] v);
    txa_we = 1'b1; txa_wdata = v; tick(); txa_we = 1'b0;
  endtask

  // present one received character and compare with the model
  task automatic rx_push(logic [8:0] d, string req);
    bit is_a, pass;
    is_a = m_nine && d[8];
    if (!(m_nine && m_match)) pass = 1;
    else if (is_a) pass = (d[7:0] == m_rxa);
    else pass = m_hit;
    if (m_nine && m_match && is_a) m_hit = (d[7:0] == m_rxa);
    rx_in_valid = 1'b1; rx_in_data = d;
    tick();
    rx_in_valid = 1'b0;
    check({req, " rx valid"}, rx_out_valid, pass);
    if (pass) begin
      check({req, " rx data"}, rx_out_data, d[7:0]);
      check({req, " rx flag"}, rx_out_addr, is_a);
    end
  endtask

  task automatic tx_send(logic [8:0] d);
    tx_in_valid = 1'b1; tx_in_data = d;
    while (!tx_in_ready) tick();
    tick();
    tx_in_valid = 1'b0;
  endtask

  task automatic take(logic [8:0] exp, string req);
    check({req, " tx valid"}, tx_out_valid, 1);
    check({req, " tx data"}, tx_out_data, exp);
    tx_out_ready = 1'b1; tick(); tx_out_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    check("R1 ctl", ctl_q, 0);
    check("R1 rxa", rx_addr_q, 0);
    check("R1 txa", tx_addr_q, 0);
    check("R1 rx valid", rx_out_valid, 0);
    check("R1 tx valid", tx_out_valid, 0);

    // R2..R5: every address value in all four mode combinations
    for (int mode = 0; mode < 4; mode++) begin
      wr_ctl(mode[3:0]);
      wr_rxa(8'h5A);
      m_rxa = 8'h5A;
      rx_push({1'b0, 8'hE1}, "R5 data before address");
      for (int a = 0; a < 256; a++) begin
        rx_push({1'b1, a[7:0]}, mode == 3 ? "R4" : (mode == 1 ? "R3" : "R2"));
        rx_push({1'b0, a[7:0] ^ 8'h33}, mode == 3 ? "R5" : "R2");
      end
      // R6: strobe lasts one cycle
      tick();
      check("R6 single strobe", rx_out_valid, 0);
    end

    // R7: deferred receive address update
    wr_ctl(4'h3);
    rx_busy = 1'b1;
    wr_rxa(8'h11);
    check("R7 held while busy", rx_addr_q, 8'h5A);
    wr_rxa(8'h22);
    rx_push({1'b1, 8'h22}, "R7 old address in use");
    check("R7 still held", rx_addr_q, 8'h5A);
    rx_busy = 1'b0;
    tick();
    check("R7 applied after frame", rx_addr_q, 8'h22);
    m_rxa = 8'h22;
    rx_push({1'b1, 8'h22}, "R7 new address matches");
    rx_push({1'b0, 8'h9C}, "R5 data after match");

    // R11: off clears match state, back on drops data
    wr_ctl(4'h0);
    rx_push({1'b1, 8'h77}, "R11 off passes all");
    wr_ctl(4'h3);
    rx_push({1'b0, 8'h44}, "R11 data dropped after re-enable");
    rx_push({1'b1, 8'h22}, "R11 match again");
    rx_push({1'b0, 8'h45}, "R11 data after match");

    // R8 / R2 / R10 transmit ninth bit
    wr_txa(8'hC5);
    check("R9 txa", tx_addr_q, 8'hC5);
    wr_ctl(4'h0);
    tx_send(9'h1C3);
    repeat (3) tick();
    take(9'h0C3, "R2 R10 nine off, held while stalled");
    wr_ctl(4'h1);
    tx_send(9'h1C3);
    take(9'h0C3, "R8 mode 0 forces ninth low");
    wr_ctl(4'h9);
    tx_send(9'h1C3);
    take(9'h1C3, "R8 mode 1 keeps ninth");
    tx_send(9'h03C);
    take(9'h03C, "R8 mode 1 low ninth");

    // R9: send request without nine-bit mode is dropped
    wr_ctl(4'h4);
    check("R9 request dropped", ctl_q, 4'h0);
    tick();
    check("R9 nothing sent", tx_out_valid, 0);

    // R9: request on an idle path
    wr_ctl(4'h5);
    tick();
    check("R9 self clear", ctl_q, 4'h1);
    take(9'h1C5, "R9 address sent");

    // R9: request overtakes pending host data
    tx_send(9'h011);
    wr_ctl(4'h5);
    check("R9 pending", ctl_q, 4'h5);
    tx_in_valid = 1'b1; tx_in_data = 9'h022;
    check("R9 host refused", tx_in_ready, 0);
    take(9'h011, "R9 earlier data first");
    check("R9 cleared on load", ctl_q, 4'h1);
    take(9'h1C5, "R9 address before data");
    tx_in_valid = 1'b0;
    take(9'h022, "R9 data after address");
    check("R9 path empty", tx_out_valid, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule